// File: doc/BRIEF.md
# Static-Mapped Protected RAM Allocator

This block keeps an on-chip RAM split into eight equal banks and shares it among three requesters: a processor, a network end-point and a switch engine. During start-up a small table is written that gives every bank to exactly one requester, or to none. Once the start-up-complete bit is set the table is frozen until the next reset. Each requester then reaches its own banks over a private path with no arbitration. Its read data therefore returns one cycle after the request, whatever the other two requesters are doing.

Every stored word carries single-error-correct, double-error-detect check bits. A read with one flipped bit returns corrected data and counts a corrected error. A read with two flipped bits returns an error response and counts an uncorrectable error. Once the table is frozen, a background scrubber in each bank steps through the words in cycles when the bank's owner is not using it. It writes back corrected data for any word that holds a single-bit error.

If a requester touches a bank it does not own, the access is refused with an error response. The requester index and the bank index are logged. A fault-injection mask on the write path lets test software store deliberately corrupted codewords.

Top module: `bank_guard_ram`

## Requirements
- R1: After reset every bank is unassigned (owner code 3 in every `owner_map` field), `cfg_locked` is 0, both error counters are 0, `viol_seen` is 0 and no response is valid.
- R2: While `cfg_locked` is 0, a cycle with `cfg_we` high sets the owner of bank `cfg_bank` to `cfg_owner`. Owner codes are 0 for the processor, 1 for the end-point, 2 for the switch engine and 3 for no owner. Bank b appears at `owner_map[2b+1:2b]`.
- R3: A cycle with `cfg_lock` high sets `cfg_locked`. From then on `cfg_we` has no effect on the table until reset.
- R4: Requester addresses are {bank index in the upper bits, word index in the lower bits}. An access to an owned bank returns `rsp_valid` exactly one cycle after the request. For a read, the stored data comes back in that same response cycle, even when all three requesters access their banks in the same cycle.
- R5: An access to a bank whose owner code differs from the requester's index gets `rsp_err`=1 and read data 0. A refused write leaves memory unchanged. The block sets `viol_seen` and records the requester in `viol_req` and the bank in `viol_bank`. When several requesters are refused in the same cycle, the lowest requester index is logged.
- R6: A read of a word with one flipped codeword bit returns the original data with `rsp_err`=0 and adds one to `corr_count`.
- R7: A read of a word with two flipped codeword bits returns `rsp_err`=1 with data 0, adds one to `uncorr_count` and leaves `corr_count` unchanged.
- R8: The counters add every event of a cycle (simultaneous corrections from several requesters each count). They saturate at all ones.
- R9: While locked, each bank's scrubber visits one word per cycle in which the owner does not access that bank. It rewrites a word holding a single-bit error with its corrected codeword and adds one to `corr_count`. A later read of that word is clean and adds nothing.
- R10: `err_inject` is XORed into the 39-bit codeword of every write in that cycle. Codeword bit 0 is the overall parity. Bits 1, 2, 4, 8, 16 and 32 are check bits. The 32 data bits fill the remaining positions in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 3 | Request strobe, one bit per requester |
| req_we | input | 3 | 1 = write, 0 = read, per requester |
| req_addr | input | 21 | Per requester 7 bits: {bank[2:0], word[3:0]} |
| req_wdata | input | 96 | Per requester 32-bit write data |
| err_inject | input | 39 | Codeword XOR mask applied to writes |
| cfg_we | input | 1 | Ownership table write strobe |
| cfg_bank | input | 3 | Bank being assigned |
| cfg_owner | input | 2 | Owner code written |
| cfg_lock | input | 1 | Start-up-complete strobe |
| rsp_valid | output | 3 | Response valid, per requester |
| rsp_err | output | 3 | Error response, per requester |
| rsp_rdata | output | 96 | Per requester 32-bit read data |
| owner_map | output | 16 | Ownership table, 2 bits per bank |
| cfg_locked | output | 1 | Table frozen |
| corr_count | output | 8 | Corrected-error counter |
| uncorr_count | output | 8 | Uncorrectable-error counter |
| viol_seen | output | 1 | An ownership violation has occurred |
| viol_req | output | 2 | Requester of the last logged violation |
| viol_bank | output | 3 | Bank of the last logged violation |

## Verification
The bench flips each of the 39 codeword positions in turn, including the parity bit and every check bit. A decoder with a misplaced check position would return wrong data or miss the count. Double flips that cancel the overall parity, or that give a syndrome pointing at a check bit, must be reported as uncorrectable instead of being "fixed" into a wrong value. Simultaneous refused accesses check the logging priority, and a refused write followed by an owner read shows whether the write was blocked at memory. The scrubber case requires exactly one count for an injected error followed by a clean read. A table write after locking, and a counter driven past 255, expose a missing freeze or wrap-around.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
  localparam int DATA_W = 32;
  localparam int PAR_W  = 6;
  localparam int CODE_W = DATA_W + PAR_W + 1;
  localparam int OWN_W  = 2;
  localparam logic [OWN_W-1:0] OWN_NONE = 2'd3;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              double;
  } dec_t;

  function automatic logic is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Hamming positions 1..CODE_W-1, overall parity at bit 0
  function automatic code_t ecc_encode(logic [DATA_W-1:0] d);
    code_t c;
    int k;
    logic [PAR_W-1:0] s;
    c = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++)
      if (!is_pow2(p)) begin
        c[p] = d[k];
        k++;
      end
    s = '0;
    for (int p = 1; p < CODE_W; p++)
      if (c[p]) s ^= PAR_W'(p);
    for (int i = 0; i < PAR_W; i++) c[1 << i] = s[i];
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic dec_t ecc_decode(code_t c);
    dec_t r;
    logic [PAR_W-1:0] s;
    logic par;
    code_t f;
    int k;
    s = '0;
    for (int p = 1; p < CODE_W; p++)
      if (c[p]) s ^= PAR_W'(p);
    par = ^c;
    f = c;
    r.single = par;
    r.double = !par && (s != '0);
    if (par && int'(s) >= CODE_W) begin
      r.single = 1'b0;
      r.double = 1'b1;
    end else if (par && s != '0) begin
      f[s] = ~f[s];
    end
    r.data = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++)
      if (!is_pow2(p)) begin
        r.data[k] = f[p];
        k++;
      end
    return r;
  endfunction
endpackage

// File: rtl/bgr_owner_table.sv
module bgr_owner_table
  import bgr_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BSEL_W = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [BSEL_W-1:0]          cfg_bank,
  input  logic [OWN_W-1:0]           cfg_owner,
  input  logic                       cfg_lock,
  output logic                       locked,
  output logic [NUM_BANKS*OWN_W-1:0] owner_map
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_map <= {NUM_BANKS{OWN_NONE}};
      locked    <= 1'b0;
    end else begin
      if (cfg_lock) locked <= 1'b1;
      if (cfg_we && !locked) owner_map[int'(cfg_bank)*OWN_W +: OWN_W] <= cfg_owner;
    end
  end
endmodule

// File: rtl/bgr_bank.sv
module bgr_bank
  import bgr_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_on,
  input  logic              busy,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  code_t             wr_code,
  input  logic [WORD_W-1:0] rd_word,
  output code_t             rd_code,
  output logic              scrub_fix
);
  code_t mem [WORDS];
  logic [WORD_W-1:0] ptr;
  dec_t sd;
  logic scrub_step;

  assign rd_code    = mem[rd_word];
  assign sd         = ecc_decode(mem[ptr]);
  assign scrub_step = scrub_on && !busy;
  assign scrub_fix  = scrub_step && sd.single && !sd.double;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word] <= wr_code;
    else if (scrub_fix) mem[ptr] <= ecc_encode(sd.data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (scrub_step) ptr <= (int'(ptr) == WORDS - 1) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/bgr_port.sv
module bgr_port
  import bgr_pkg::*;
#(
  parameter int REQ_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  code_t             inject,
  input  logic [OWN_W-1:0]  bank_owner,
  input  code_t             rd_code,
  output logic              own_ok,
  output logic              viol,
  output code_t             wr_code,
  output logic              corr_evt,
  output logic              uncorr_evt,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  dec_t dec;

  assign own_ok     = valid && (bank_owner == OWN_W'(REQ_ID));
  assign viol       = valid && !own_ok;
  assign dec        = ecc_decode(rd_code);
  assign corr_evt   = own_ok && !we && dec.single;
  assign uncorr_evt = own_ok && !we && dec.double;
  assign wr_code    = ecc_encode(wdata) ^ inject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid;
      rsp_err   <= viol || uncorr_evt;
      rsp_rdata <= (own_ok && !we && !dec.double) ? dec.data : '0;
    end
  end
endmodule

// File: rtl/bank_guard_ram.sv
module bank_guard_ram
  import bgr_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int NUM_REQ    = 3,
  parameter int BANK_WORDS = 16,
  parameter int CNT_W      = 8,
  localparam int BSEL_W = $clog2(NUM_BANKS),
  localparam int WORD_W = $clog2(BANK_WORDS),
  localparam int ADDR_W = BSEL_W + WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REQ-1:0]         req_valid,
  input  logic [NUM_REQ-1:0]         req_we,
  input  logic [NUM_REQ*ADDR_W-1:0]  req_addr,
  input  logic [NUM_REQ*DATA_W-1:0]  req_wdata,
  input  logic [CODE_W-1:0]          err_inject,
  input  logic                       cfg_we,
  input  logic [BSEL_W-1:0]          cfg_bank,
  input  logic [OWN_W-1:0]           cfg_owner,
  input  logic                       cfg_lock,
  output logic [NUM_REQ-1:0]         rsp_valid,
  output logic [NUM_REQ-1:0]         rsp_err,
  output logic [NUM_REQ*DATA_W-1:0]  rsp_rdata,
  output logic [NUM_BANKS*OWN_W-1:0] owner_map,
  output logic                       cfg_locked,
  output logic [CNT_W-1:0]           corr_count,
  output logic [CNT_W-1:0]           uncorr_count,
  output logic                       viol_seen,
  output logic [OWN_W-1:0]           viol_req,
  output logic [BSEL_W-1:0]          viol_bank
);
  // named internal events, observed by the bound checker
  logic [NUM_REQ-1:0]   own_ok, viol_evt, corr_evt, uncorr_evt;
  logic [NUM_BANKS-1:0] scrub_fix;
  logic [BSEL_W-1:0]    r_bank [NUM_REQ];
  logic [WORD_W-1:0]    r_word [NUM_REQ];
  logic [OWN_W-1:0]     r_own  [NUM_REQ];
  code_t                r_wcode [NUM_REQ];
  code_t                b_rcode [NUM_BANKS];

  function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] c, int n);
    longint s;
    longint top;
    s   = longint'(c) + longint'(n);
    top = (longint'(1) << CNT_W) - 1;
    return (s > top) ? CNT_W'(top) : CNT_W'(s);
  endfunction

  bgr_owner_table #(.NUM_BANKS(NUM_BANKS)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_owner(cfg_owner), .cfg_lock(cfg_lock), .locked(cfg_locked),
    .owner_map(owner_map)
  );

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    assign r_bank[r] = req_addr[r*ADDR_W + WORD_W +: BSEL_W];
    assign r_word[r] = req_addr[r*ADDR_W +: WORD_W];
    assign r_own[r]  = owner_map[int'(r_bank[r])*OWN_W +: OWN_W];

    bgr_port #(.REQ_ID(r)) u_port (
      .clk(clk), .rst_n(rst_n), .valid(req_valid[r]), .we(req_we[r]),
      .wdata(req_wdata[r*DATA_W +: DATA_W]), .inject(err_inject),
      .bank_owner(r_own[r]), .rd_code(b_rcode[r_bank[r]]),
      .own_ok(own_ok[r]), .viol(viol_evt[r]), .wr_code(r_wcode[r]),
      .corr_evt(corr_evt[r]), .uncorr_evt(uncorr_evt[r]),
      .rsp_valid(rsp_valid[r]), .rsp_err(rsp_err[r]),
      .rsp_rdata(rsp_rdata[r*DATA_W +: DATA_W])
    );
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [OWN_W-1:0]  own;
    logic              busy, wen;
    logic [WORD_W-1:0] word;
    code_t             wcode;

    assign own = owner_map[b*OWN_W +: OWN_W];

    // only the owner can steer this bank: no arbitration
    always_comb begin
      busy  = 1'b0;
      wen   = 1'b0;
      word  = '0;
      wcode = '0;
      for (int r = 0; r < NUM_REQ; r++)
        if (own == OWN_W'(r) && req_valid[r] && r_bank[r] == BSEL_W'(b)) begin
          busy  = 1'b1;
          wen   = req_we[r];
          word  = r_word[r];
          wcode = r_wcode[r];
        end
    end

    bgr_bank #(.WORDS(BANK_WORDS)) u_bank (
      .clk(clk), .rst_n(rst_n), .scrub_on(cfg_locked), .busy(busy),
      .wr_en(wen), .wr_word(word), .wr_code(wcode), .rd_word(word),
      .rd_code(b_rcode[b]), .scrub_fix(scrub_fix[b])
    );
  end

  logic                v_hit;
  logic [OWN_W-1:0]    v_req;
  logic [BSEL_W-1:0]   v_bank;

  always_comb begin
    v_hit  = 1'b0;
    v_req  = '0;
    v_bank = '0;
    for (int r = NUM_REQ - 1; r >= 0; r--)
      if (viol_evt[r]) begin
        v_hit  = 1'b1;
        v_req  = OWN_W'(r);
        v_bank = r_bank[r];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      corr_count   <= '0;
      uncorr_count <= '0;
      viol_seen    <= 1'b0;
      viol_req     <= '0;
      viol_bank    <= '0;
    end else begin
      corr_count   <= sat_add(corr_count, $countones(corr_evt) + $countones(scrub_fix));
      uncorr_count <= sat_add(uncorr_count, $countones(uncorr_evt));
      if (v_hit) begin
        viol_seen <= 1'b1;
        viol_req  <= v_req;
        viol_bank <= v_bank;
      end
    end
  end
endmodule

// File: rtl/bank_guard_ram_chk.sv
module bank_guard_ram_chk
  import bgr_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int NUM_REQ   = 3,
  parameter int CNT_W     = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_REQ-1:0]         req_valid,
  input logic [NUM_REQ-1:0]         rsp_valid,
  input logic [NUM_REQ-1:0]         rsp_err,
  input logic [NUM_REQ-1:0]         viol_evt,
  input logic [NUM_REQ-1:0]         uncorr_evt,
  input logic                       cfg_locked,
  input logic [NUM_BANKS*OWN_W-1:0] owner_map,
  input logic [CNT_W-1:0]           corr_count,
  input logic [CNT_W-1:0]           uncorr_count
);
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_r
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[r] |=> rsp_valid[r]); // R4
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[r] |=> !rsp_valid[r]); // R4
    AST_VIOL_ERR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      viol_evt[r] |=> rsp_err[r]); // R5
    AST_DOUBLE_ERR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      uncorr_evt[r] |=> rsp_err[r]); // R7
  end

  AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> cfg_locked && $stable(owner_map)); // R3
  AST_CORR_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> corr_count >= $past(corr_count)); // R8
  AST_UNCORR_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> uncorr_count >= $past(uncorr_count)); // R8
endmodule

bind bank_guard_ram bank_guard_ram_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_REQ(NUM_REQ), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .viol_evt(viol_evt), .uncorr_evt(uncorr_evt),
  .cfg_locked(cfg_locked), .owner_map(owner_map), .corr_count(corr_count),
  .uncorr_count(uncorr_count)
);

// File: tb/bank_guard_ram_tb.sv
module bank_guard_ram_tb;
  localparam int NR = 3;
  localparam int NB = 8;
  localparam int AW = 7;
  localparam int DW = 32;
  localparam int CW = 39;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0] req_valid = '0, req_we = '0;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR*DW-1:0] req_wdata = '0;
  logic [CW-1:0] err_inject = '0;
  logic cfg_we = 1'b0, cfg_lock = 1'b0;
  logic [2:0] cfg_bank = '0;
  logic [1:0] cfg_owner = '0;
  logic [NR-1:0] rsp_valid, rsp_err;
  logic [NR*DW-1:0] rsp_rdata;
  logic [NB*2-1:0] owner_map;
  logic cfg_locked, viol_seen;
  logic [7:0] corr_count, uncorr_count;
  logic [1:0] viol_req;
  logic [2:0] viol_bank;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [1:0] tbl [NB];

  always #4 clk = ~clk;

  bank_guard_ram u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_map();
    logic [15:0] m;
    for (int b = 0; b < NB; b++) m[b*2 +: 2] = tbl[b];
    return m;
  endfunction

  function automatic logic [31:0] pat(int r, int b, int w);
    return 32'h5A5A_0000 ^ (32'(r + 1) << 28) ^ (32'(b) << 12) ^ (32'(w) * 32'h0011_0011);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_req(int r, bit we, int b, int w, logic [31:0] d);
    req_valid[r] = 1'b1;
    req_we[r] = we;
    req_addr[r*AW +: AW] = {3'(b), 4'(w)};
    req_wdata[r*DW +: DW] = d;
  endtask

  task automatic clr_req();
    req_valid = '0;
    req_we = '0;
    err_inject = '0;
  endtask

  task automatic op(int r, bit we, int b, int w, logic [31:0] d);
    set_req(r, we, b, w, d);
    tick();
    clr_req();
  endtask

  task automatic assign_bank(int b, int o);
    cfg_we = 1'b1;
    cfg_bank = 3'(b);
    cfg_owner = 2'(o);
    tick();
    cfg_we = 1'b0;
    if (!cfg_locked) tbl[b] = 2'(o);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clr_req();
    repeat (3) tick();
    rst_n = 1'b1;
    for (int b = 0; b < NB; b++) tbl[b] = 2'd3;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0;
    do_reset();
    // R1 reset state
    chk("R1 owner_map", 64'(owner_map), 64'hFFFF);
    chk("R1 locked", 64'(cfg_locked), 0);
    chk("R1 corr", 64'(corr_count), 0);
    chk("R1 uncorr", 64'(uncorr_count), 0);
    chk("R1 viol_seen", 64'(viol_seen), 0);
    chk("R1 rsp_valid", 64'(rsp_valid), 0);

    // R2 table programming: requester r owns banks r and r+3
    for (int b = 0; b < 6; b++) assign_bank(b, b % 3);
    chk("R2 owner_map", 64'(owner_map), 64'(exp_map()));

    // R4 sweep: all requesters write both banks concurrently, then read back
    for (int k = 0; k < 2; k++)
      for (int w = 0; w < 16; w++) begin
        for (int r = 0; r < NR; r++) set_req(r, 1'b1, r + 3*k, w, pat(r, r + 3*k, w));
        tick();
        clr_req();
        chk("R4 write rsp_valid", 64'(rsp_valid), 64'h7);
        chk("R4 write rsp_err", 64'(rsp_err), 0);
      end
    for (int k = 0; k < 2; k++)
      for (int w = 0; w < 16; w++) begin
        for (int r = 0; r < NR; r++) set_req(r, 1'b0, r + 3*k, w, '0);
        tick();
        clr_req();
        for (int r = 0; r < NR; r++)
          chk("R4 concurrent read", 64'(rsp_rdata[r*DW +: DW]), 64'(pat(r, r + 3*k, w)));
        chk("R4 read rsp_err", 64'(rsp_err), 0);
      end
    op(1, 1'b0, 4, 9, '0);
    chk("R4 lone rsp_valid", 64'(rsp_valid), 64'h2);
    tick();
    chk("R4 rsp_valid drops", 64'(rsp_valid), 0);

    // R5 violations
    op(1, 1'b0, 0, 2, '0);
    chk("R5 read err", 64'(rsp_err), 64'h2);
    chk("R5 read data zero", 64'(rsp_rdata[DW +: DW]), 0);
    chk("R5 log", 64'({viol_seen, viol_req, viol_bank}), 64'({1'b1, 2'd1, 3'd0}));
    op(2, 1'b1, 3, 4, 32'hDEAD_BEEF);
    chk("R5 write err", 64'(rsp_err), 64'h4);
    op(0, 1'b0, 3, 4, '0);
    chk("R5 refused write left memory", 64'(rsp_rdata[0 +: DW]), 64'(pat(0, 3, 4)));
    set_req(2, 1'b0, 0, 0, '0);
    set_req(1, 1'b0, 2, 0, '0);
    tick();
    clr_req();
    chk("R5 priority", 64'({viol_req, viol_bank}), 64'({2'd1, 3'd2}));
    op(0, 1'b0, 6, 0, '0);
    chk("R5 unassigned bank", 64'({rsp_err[0], viol_req, viol_bank}), 64'({1'b1, 2'd0, 3'd6}));

    // R6 / R10: every single-bit position corrected
    for (int p = 0; p < CW; p++) begin
      err_inject = CW'(1) << p;
      op(0, 1'b1, 0, 7, 32'hC0DE_0000 ^ 32'(p));
      op(0, 1'b0, 0, 7, '0);
      chk("R6 corrected data", 64'(rsp_rdata[0 +: DW]), 64'(32'hC0DE_0000 ^ 32'(p)));
      chk("R6 no err", 64'(rsp_err[0]), 0);
      chk("R6 corr count", 64'(corr_count), 64'(p + 1));
    end

    // R7 / R10 double flips
    begin
      logic [CW-1:0] dm [3];
      dm[0] = (CW'(1) << 3) | (CW'(1) << 5);
      dm[1] = (CW'(1) << 0) | (CW'(1) << 38);
      dm[2] = (CW'(1) << 1) | (CW'(1) << 2);
      for (int i = 0; i < 3; i++) begin
        err_inject = dm[i];
        op(0, 1'b1, 0, 7, 32'h1234_5678);
        op(0, 1'b0, 0, 7, '0);
        chk("R7 err", 64'(rsp_err[0]), 1);
        chk("R7 data zero", 64'(rsp_rdata[0 +: DW]), 0);
        chk("R7 uncorr count", 64'(uncorr_count), 64'(i + 1));
        chk("R7 corr unchanged", 64'(corr_count), 39);
      end
    end

    // R8 simultaneous corrections count each
    err_inject = CW'(1) << 20;
    set_req(0, 1'b1, 0, 8, 32'hAAAA_0001);
    set_req(1, 1'b1, 1, 8, 32'hBBBB_0002);
    tick();
    clr_req();
    set_req(0, 1'b0, 0, 8, '0);
    set_req(1, 1'b0, 1, 8, '0);
    tick();
    clr_req();
    chk("R8 two at once", 64'(corr_count), 41);
    chk("R8 data", 64'({rsp_rdata[DW +: DW], rsp_rdata[0 +: DW]}), 64'h BBBB_0002_AAAA_0001);
    // clean the corrupted words before locking
    op(0, 1'b1, 0, 7, 32'h0);
    op(0, 1'b1, 0, 8, 32'h0);
    op(1, 1'b1, 1, 8, 32'h0);

    // R3 lock and freeze
    cfg_lock = 1'b1;
    tick();
    cfg_lock = 1'b0;
    chk("R3 locked", 64'(cfg_locked), 1);
    assign_bank(0, 2);
    chk("R3 table frozen", 64'(owner_map), 64'(exp_map()));
    op(0, 1'b0, 0, 5, '0);
    chk("R3 owner keeps access", 64'({rsp_err[0], rsp_rdata[0 +: DW]}), 64'({1'b0, pat(0, 0, 5)}));

    // R9 scrubber repairs one injected error
    repeat (40) tick();
    c0 = corr_count;
    err_inject = CW'(1) << 10;
    op(0, 1'b1, 3, 9, 32'h5C0B_BED0);
    repeat (40) tick();
    chk("R9 scrub counted once", 64'(corr_count), 64'(c0 + 8'd1));
    op(0, 1'b0, 3, 9, '0);
    chk("R9 read after scrub", 64'(rsp_rdata[0 +: DW]), 64'h5C0B_BED0);
    chk("R9 no new count", 64'(corr_count), 64'(c0 + 8'd1));

    // R1/R3: reset reopens the table; R8 saturation
    do_reset();
    chk("R1 reset clears lock", 64'({cfg_locked, owner_map}), 64'({1'b0, 16'hFFFF}));
    assign_bank(0, 0);
    chk("R3 writable after reset", 64'(owner_map), 64'(exp_map()));
    err_inject = CW'(1) << 30;
    op(0, 1'b1, 0, 0, 32'h0F0F_0F0F);
    set_req(0, 1'b0, 0, 0, '0);
    repeat (300) tick();
    clr_req();
    chk("R8 saturates", 64'(corr_count), 64'hFF);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule